// File: doc/BRIEF.md
# Debug Translation Request Controller

This block is a small register front end that lets software push a single address translation through a shared address-translation engine and then read back the outcome. Software loads a 64-bit request address and then a request-control word. Setting the launch/busy flag in the control word starts the request. The block issues the request to the engine as an untranslated request. It competes for the engine with normal device translation traffic under a two-way round-robin arbiter, so a debug request can be delayed but is always granted. When the result arrives, the block reports it in a read-only result register.

A successful result returns the physical page number and the attribute bits. A faulting result, or an address that hits an interrupt-file entry set to memory-resident mode, produces a fault record on the fault-queue port. The result register then holds only its fault flag. The launch/busy flag can only be set by software and only cleared by the block. Its falling edge is the one moment the result register changes. Writes that arrive while a request is in flight are discarded, and a sticky error flag records that they happened. The whole interface is present only when the `CAP_DEBUG` parameter is 1.

A debug request moves through four states:

- `DX_IDLE` waits for a launch and goes to `DX_ISSUE` on a control write with bit 0 set.
- `DX_ISSUE` holds the request to the arbiter and goes to `DX_WAIT` on an engine handshake.
- `DX_WAIT` waits for the tagged engine response. A clean response goes back to `DX_IDLE`. A fault or memory-resident-mode response goes to `DX_FAULT`.
- `DX_FAULT` presents the fault record and goes to `DX_IDLE` when the fault queue accepts it.

Top module: `dbg_xlate_ctrl`

## Requirements
- R1: After reset, the address, control and result registers (word offsets 0, 1 and 2) read 0, and no request is presented to the engine.
- R2: With `CAP_DEBUG` = 0, every register reads 0, writes have no effect, and no debug request (`eng_req_dbg` = 1) is ever issued.
- R3: Control-word fields are bit 0 launch/busy, bit 1 error flag, bit 2 write intent and bits 16 and up device id. Writing the control word with bit 0 set while idle issues one engine request carrying the stored address, device id and write intent, with `eng_req_untrans` = 1 and `eng_req_dbg` = 1.
- R4: Control bit 0 is write-1-to-set. A control write with bit 0 = 0 never clears it, and it reads 1 until the request completes.
- R5: Writes to offset 0 or 1 while busy are dropped and set control bit 1. Writing 1 to bit 1 while idle clears it.
- R6: On a clean completion the result register becomes {PPN in bits 63:10, attributes in bits 9:1, 0 in bit 0}. It changes only on the cycle busy falls, and writes to offset 2 have no effect.
- R7: On an engine fault the block holds `fq_valid` with the engine's cause, the request address and the device id until `fq_ready`. Busy falls on the cycle after that handshake, and the result register then reads 1.
- R8: A response flagged as memory-resident interrupt-file mode is treated as a fault with cause 260, whatever the engine's own fault flag and cause.
- R9: Arbitration alternates between the debug and device sources. A waiting debug request loses at most one device grant before it is granted, and `dev_req_ready` is 0 while the debug request is granted.
- R10: Engine responses with `eng_rsp_dbg` = 0 are passed to the device response port in the same cycle and do not end a pending debug request.
- R11: `pmu_untrans` is 1 in each cycle where the engine accepts an untranslated request: every debug request, and a device request when `dev_req_untrans` = 1.
- R12: `bus_ready` is always 1. Read data appears on `bus_rdata` with `bus_rvalid` = 1 in the cycle after the read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access request |
| bus_ready | output | 1 | Access accepted (always 1) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_off | input | 3 | Word offset: 0 address, 1 control, 2 result |
| bus_wdata | input | 64 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 64 | Read data |
| dev_req_valid | input | 1 | Device translation request |
| dev_req_ready | output | 1 | Device request accepted |
| dev_req_iova | input | 64 | Device request address |
| dev_req_did | input | 16 | Device request id |
| dev_req_write | input | 1 | Device write intent |
| dev_req_untrans | input | 1 | Device request is untranslated |
| eng_req_valid | output | 1 | Request to the engine |
| eng_req_ready | input | 1 | Engine accepts request |
| eng_req_iova | output | 64 | Request address to engine |
| eng_req_did | output | 16 | Device id to engine |
| eng_req_write | output | 1 | Write intent to engine |
| eng_req_untrans | output | 1 | Untranslated request flag |
| eng_req_dbg | output | 1 | Request tag: 1 = debug |
| eng_rsp_valid | input | 1 | Engine response valid |
| eng_rsp_dbg | input | 1 | Response tag: 1 = debug |
| eng_rsp_fault | input | 1 | Translation faulted |
| eng_rsp_mrif | input | 1 | Hit a memory-resident-mode interrupt-file entry |
| eng_rsp_cause | input | 12 | Fault cause |
| eng_rsp_ppn | input | 54 | Physical page number |
| eng_rsp_attr | input | 9 | Permission and attribute bits |
| dev_rsp_valid | output | 1 | Device response valid |
| dev_rsp_fault | output | 1 | Device response fault |
| dev_rsp_cause | output | 12 | Device response cause |
| dev_rsp_ppn | output | 54 | Device response page number |
| dev_rsp_attr | output | 9 | Device response attributes |
| fq_valid | output | 1 | Fault record valid |
| fq_ready | input | 1 | Fault queue accepts record |
| fq_cause | output | 12 | Fault record cause |
| fq_iova | output | 64 | Fault record address |
| fq_did | output | 16 | Fault record device id |
| pmu_untrans | output | 1 | Untranslated-request count event |

## Verification
The bench builds the main instance with the defaults (`CAP_DEBUG` = 1, 16-bit device id). With these, the full launch, issue, wait and fault paths can be exercised, including device ids in the upper control bits and page numbers that fill the result register. A second instance built with `CAP_DEBUG` = 0 shares the same inputs. It shows that the disabled variant reads zero and never tags a request as debug, even while the enabled copy is launching one. The arbitration corner is driven by a device port that requests every cycle. This makes the round-robin bound on debug delay observable at the engine port.

// File: rtl/dbgx_pkg.sv
package dbgx_pkg;
    localparam int OFF_W      = 3;
    localparam int CTL_DID_LO = 16;
    localparam int CAUSE_W    = 12;
    localparam int ATTR_W     = 9;

    localparam logic [OFF_W-1:0] OFF_ADDR = 3'd0;
    localparam logic [OFF_W-1:0] OFF_CTL  = 3'd1;
    localparam logic [OFF_W-1:0] OFF_RSLT = 3'd2;

    localparam logic [CAUSE_W-1:0] CAUSE_TYPE_DENIED = 12'd260;

    typedef enum logic [1:0] {
        DX_IDLE,
        DX_ISSUE,
        DX_WAIT,
        DX_FAULT
    } dx_state_e;
endpackage

// File: rtl/dbgx_regs.sv
module dbgx_regs
    import dbgx_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int DID_W     = 16,
    parameter bit CAP_DEBUG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [OFF_W-1:0]  bus_off,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              busy,
    input  logic [DATA_W-1:0] rslt,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] addr_q,
    output logic [DID_W-1:0]  did_q,
    output logic              wr_q,
    output logic              launch
);
    logic              wr_en;
    logic              hit_addr;
    logic              hit_ctl;
    logic              err_q;
    logic [DATA_W-1:0] ctl_view;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        ctl_view                          = '0;
        ctl_view[0]                       = busy;
        ctl_view[1]                       = err_q;
        ctl_view[2]                       = wr_q;
        ctl_view[CTL_DID_LO +: DID_W]     = did_q;
    end

    generate
        if (CAP_DEBUG) begin : g_present
            assign wr_en = bus_valid & bus_write;
            always_comb begin
                unique case (bus_off)
                    OFF_ADDR: rd_mux = addr_q;
                    OFF_CTL:  rd_mux = ctl_view;
                    OFF_RSLT: rd_mux = rslt;
                    default:  rd_mux = '0;
                endcase
            end
        end else begin : g_absent
            assign wr_en  = 1'b0;
            assign rd_mux = '0;
        end
    endgenerate

    assign hit_addr = wr_en && (bus_off == OFF_ADDR);
    assign hit_ctl  = wr_en && (bus_off == OFF_CTL);
    assign launch   = hit_ctl && !busy && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            did_q  <= '0;
            wr_q   <= 1'b0;
            err_q  <= 1'b0;
        end else if ((hit_addr || hit_ctl) && busy) begin
            err_q <= 1'b1;
        end else begin
            if (hit_addr) begin
                addr_q <= bus_wdata;
            end
            if (hit_ctl) begin
                did_q <= bus_wdata[CTL_DID_LO +: DID_W];
                wr_q  <= bus_wdata[2];
                if (bus_wdata[1]) begin
                    err_q <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_valid && !bus_write;
            if (bus_valid && !bus_write) begin
                bus_rdata <= rd_mux;
            end
        end
    end
endmodule

// File: rtl/dbgx_fsm.sv
module dbgx_fsm
    import dbgx_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int PPN_W  = DATA_W - ATTR_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic               granted,
    input  logic               rsp_hit,
    input  logic               rsp_fault,
    input  logic               rsp_mrif,
    input  logic [CAUSE_W-1:0] rsp_cause,
    input  logic [PPN_W-1:0]   rsp_ppn,
    input  logic [ATTR_W-1:0]  rsp_attr,
    input  logic               fq_ready,
    output logic               busy,
    output logic               issue,
    output logic               waiting,
    output logic               fq_valid,
    output logic [CAUSE_W-1:0] fq_cause,
    output logic [DATA_W-1:0]  rslt
);
    dx_state_e st_q, st_d;
    logic      rsp_bad;

    assign rsp_bad = rsp_fault || rsp_mrif;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= DX_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DX_IDLE:  if (launch)   st_d = DX_ISSUE;
            DX_ISSUE: if (granted)  st_d = DX_WAIT;
            DX_WAIT:  if (rsp_hit)  st_d = rsp_bad ? DX_FAULT : DX_IDLE;
            DX_FAULT: if (fq_ready) st_d = DX_IDLE;
            default:                st_d = DX_IDLE;
        endcase
    end

    always_comb begin
        busy     = (st_q != DX_IDLE);
        issue    = (st_q == DX_ISSUE);
        waiting  = (st_q == DX_WAIT);
        fq_valid = (st_q == DX_FAULT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fq_cause <= '0;
            rslt     <= '0;
        end else begin
            if (waiting && rsp_hit) begin
                fq_cause <= rsp_mrif ? CAUSE_TYPE_DENIED : rsp_cause;
                if (!rsp_bad) begin
                    rslt <= {rsp_ppn, rsp_attr, 1'b0};
                end
            end
            if (fq_valid && fq_ready) begin
                rslt <= {{(DATA_W-1){1'b0}}, 1'b1};
            end
        end
    end
endmodule

// File: rtl/dbgx_arb.sv
module dbgx_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic dbg_req,
    input  logic dev_req,
    input  logic eng_ready,
    output logic gnt_dbg,
    output logic gnt_dev,
    output logic eng_valid
);
    logic favor_dbg_q;

    assign gnt_dbg   = dbg_req && (!dev_req || favor_dbg_q);
    assign gnt_dev   = dev_req && !gnt_dbg;
    assign eng_valid = dbg_req || dev_req;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            favor_dbg_q <= 1'b0;
        end else if (eng_valid && eng_ready) begin
            favor_dbg_q <= gnt_dev;
        end
    end
endmodule

// File: rtl/dbg_xlate_ctrl.sv
module dbg_xlate_ctrl
    import dbgx_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int DID_W     = 16,
    parameter bit CAP_DEBUG = 1'b1,
    parameter int PPN_W     = DATA_W - ATTR_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    output logic               bus_ready,
    input  logic               bus_write,
    input  logic [OFF_W-1:0]   bus_off,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic               bus_rvalid,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               dev_req_valid,
    output logic               dev_req_ready,
    input  logic [DATA_W-1:0]  dev_req_iova,
    input  logic [DID_W-1:0]   dev_req_did,
    input  logic               dev_req_write,
    input  logic               dev_req_untrans,
    output logic               eng_req_valid,
    input  logic               eng_req_ready,
    output logic [DATA_W-1:0]  eng_req_iova,
    output logic [DID_W-1:0]   eng_req_did,
    output logic               eng_req_write,
    output logic               eng_req_untrans,
    output logic               eng_req_dbg,
    input  logic               eng_rsp_valid,
    input  logic               eng_rsp_dbg,
    input  logic               eng_rsp_fault,
    input  logic               eng_rsp_mrif,
    input  logic [CAUSE_W-1:0] eng_rsp_cause,
    input  logic [PPN_W-1:0]   eng_rsp_ppn,
    input  logic [ATTR_W-1:0]  eng_rsp_attr,
    output logic               dev_rsp_valid,
    output logic               dev_rsp_fault,
    output logic [CAUSE_W-1:0] dev_rsp_cause,
    output logic [PPN_W-1:0]   dev_rsp_ppn,
    output logic [ATTR_W-1:0]  dev_rsp_attr,
    output logic               fq_valid,
    input  logic               fq_ready,
    output logic [CAUSE_W-1:0] fq_cause,
    output logic [DATA_W-1:0]  fq_iova,
    output logic [DID_W-1:0]   fq_did,
    output logic               pmu_untrans
);
    logic              dbg_busy;
    logic              dbg_issue;
    logic              dbg_wait;
    logic              dbg_launch;
    logic [DATA_W-1:0] dbg_rslt;
    logic [DATA_W-1:0] dbg_addr;
    logic [DID_W-1:0]  dbg_did;
    logic              dbg_wr;
    logic              gnt_dbg;
    logic              gnt_dev;

    assign bus_ready = 1'b1;

    dbgx_regs #(
        .DATA_W(DATA_W), .DID_W(DID_W), .CAP_DEBUG(CAP_DEBUG)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_off(bus_off), .bus_wdata(bus_wdata),
        .busy(dbg_busy), .rslt(dbg_rslt),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .addr_q(dbg_addr), .did_q(dbg_did), .wr_q(dbg_wr),
        .launch(dbg_launch)
    );

    dbgx_arb u_arb (
        .clk(clk), .rst_n(rst_n),
        .dbg_req(dbg_issue), .dev_req(dev_req_valid),
        .eng_ready(eng_req_ready),
        .gnt_dbg(gnt_dbg), .gnt_dev(gnt_dev),
        .eng_valid(eng_req_valid)
    );

    dbgx_fsm #(.DATA_W(DATA_W), .PPN_W(PPN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .launch(dbg_launch),
        .granted(gnt_dbg && eng_req_ready),
        .rsp_hit(eng_rsp_valid && eng_rsp_dbg),
        .rsp_fault(eng_rsp_fault), .rsp_mrif(eng_rsp_mrif),
        .rsp_cause(eng_rsp_cause), .rsp_ppn(eng_rsp_ppn),
        .rsp_attr(eng_rsp_attr), .fq_ready(fq_ready),
        .busy(dbg_busy), .issue(dbg_issue), .waiting(dbg_wait),
        .fq_valid(fq_valid), .fq_cause(fq_cause), .rslt(dbg_rslt)
    );

    assign dev_req_ready   = gnt_dev && eng_req_ready;
    assign eng_req_dbg     = gnt_dbg;
    assign eng_req_iova    = gnt_dbg ? dbg_addr : dev_req_iova;
    assign eng_req_did     = gnt_dbg ? dbg_did  : dev_req_did;
    assign eng_req_write   = gnt_dbg ? dbg_wr   : dev_req_write;
    assign eng_req_untrans = gnt_dbg || dev_req_untrans;
    assign pmu_untrans     = eng_req_valid && eng_req_ready && eng_req_untrans;

    assign dev_rsp_valid = eng_rsp_valid && !eng_rsp_dbg;
    assign dev_rsp_fault = eng_rsp_fault;
    assign dev_rsp_cause = eng_rsp_cause;
    assign dev_rsp_ppn   = eng_rsp_ppn;
    assign dev_rsp_attr  = eng_rsp_attr;

    assign fq_iova = dbg_addr;
    assign fq_did  = dbg_did;
endmodule

// File: rtl/dbg_xlate_ctrl_chk.sv
module dbg_xlate_ctrl_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              waiting,
    input logic              issue,
    input logic [DATA_W-1:0] rslt,
    input logic              eng_req_valid,
    input logic              eng_req_ready,
    input logic              eng_req_dbg,
    input logic              dev_req_valid,
    input logic              dev_req_ready,
    input logic              eng_rsp_valid,
    input logic              eng_rsp_dbg,
    input logic              eng_rsp_fault,
    input logic              eng_rsp_mrif,
    input logic              fq_valid,
    input logic              fq_ready,
    input logic [11:0]       fq_cause
);
    logic [1:0] lost_q;
    logic       finish_now;

    assign finish_now = (waiting && eng_rsp_valid && eng_rsp_dbg &&
                         !eng_rsp_fault && !eng_rsp_mrif) ||
                        (fq_valid && fq_ready);

    always_ff @(posedge clk) begin
        if (!rst_n || !issue) begin
            lost_q <= '0;
        end else if (dev_req_valid && dev_req_ready && lost_q != 2'd3) begin
            lost_q <= lost_q + 2'd1;
        end
    end

    p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !finish_now |=> busy);

    p_rslt_only_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> $stable(rslt));

    p_fq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fq_valid && !fq_ready |=> fq_valid && $stable(fq_cause));

    p_mrif_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        waiting && eng_rsp_valid && eng_rsp_dbg && eng_rsp_mrif
        |=> fq_valid && fq_cause == 12'd260);

    p_bounded_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lost_q <= 2'd1);

    p_dbg_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req_valid && eng_req_dbg |-> !dev_req_ready);
endmodule

bind dbg_xlate_ctrl dbg_xlate_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .busy(dbg_busy), .waiting(dbg_wait), .issue(dbg_issue), .rslt(dbg_rslt),
    .eng_req_valid(eng_req_valid), .eng_req_ready(eng_req_ready),
    .eng_req_dbg(eng_req_dbg),
    .dev_req_valid(dev_req_valid), .dev_req_ready(dev_req_ready),
    .eng_rsp_valid(eng_rsp_valid), .eng_rsp_dbg(eng_rsp_dbg),
    .eng_rsp_fault(eng_rsp_fault), .eng_rsp_mrif(eng_rsp_mrif),
    .fq_valid(fq_valid), .fq_ready(fq_ready), .fq_cause(fq_cause)
);

// File: tb/dbg_xlate_ctrl_test.sv
module dbg_xlate_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        bus_valid = 0, bus_write = 0;
    logic [2:0]  bus_off = 0;
    logic [63:0] bus_wdata = 0;
    logic        dev_req_valid = 0, dev_req_write = 0, dev_req_untrans = 0;
    logic [63:0] dev_req_iova = 0;
    logic [15:0] dev_req_did = 0;
    logic        eng_req_ready = 1;
    logic        eng_rsp_valid = 0, eng_rsp_dbg = 0, eng_rsp_fault = 0, eng_rsp_mrif = 0;
    logic [11:0] eng_rsp_cause = 0;
    logic [53:0] eng_rsp_ppn = 0;
    logic [8:0]  eng_rsp_attr = 0;
    logic        fq_ready = 0;

    logic        bus_ready, bus_rvalid, dev_req_ready, eng_req_valid;
    logic [63:0] bus_rdata, eng_req_iova, fq_iova;
    logic [15:0] eng_req_did, fq_did;
    logic        eng_req_write, eng_req_untrans, eng_req_dbg;
    logic        dev_rsp_valid, dev_rsp_fault, fq_valid, pmu_untrans;
    logic [11:0] dev_rsp_cause, fq_cause;
    logic [53:0] dev_rsp_ppn;
    logic [8:0]  dev_rsp_attr;

    logic        nc_bus_ready, nc_bus_rvalid, nc_dev_req_ready, nc_eng_req_valid;
    logic [63:0] nc_bus_rdata, nc_eng_req_iova, nc_fq_iova;
    logic [15:0] nc_eng_req_did, nc_fq_did;
    logic        nc_eng_req_write, nc_eng_req_untrans, nc_eng_req_dbg;
    logic        nc_dev_rsp_valid, nc_dev_rsp_fault, nc_fq_valid, nc_pmu_untrans;
    logic [11:0] nc_dev_rsp_cause, nc_fq_cause;
    logic [53:0] nc_dev_rsp_ppn;
    logic [8:0]  nc_dev_rsp_attr;

    dbg_xlate_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
        .bus_off(bus_off), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .dev_req_valid(dev_req_valid), .dev_req_ready(dev_req_ready),
        .dev_req_iova(dev_req_iova), .dev_req_did(dev_req_did),
        .dev_req_write(dev_req_write), .dev_req_untrans(dev_req_untrans),
        .eng_req_valid(eng_req_valid), .eng_req_ready(eng_req_ready),
        .eng_req_iova(eng_req_iova), .eng_req_did(eng_req_did),
        .eng_req_write(eng_req_write), .eng_req_untrans(eng_req_untrans),
        .eng_req_dbg(eng_req_dbg),
        .eng_rsp_valid(eng_rsp_valid), .eng_rsp_dbg(eng_rsp_dbg),
        .eng_rsp_fault(eng_rsp_fault), .eng_rsp_mrif(eng_rsp_mrif),
        .eng_rsp_cause(eng_rsp_cause), .eng_rsp_ppn(eng_rsp_ppn),
        .eng_rsp_attr(eng_rsp_attr),
        .dev_rsp_valid(dev_rsp_valid), .dev_rsp_fault(dev_rsp_fault),
        .dev_rsp_cause(dev_rsp_cause), .dev_rsp_ppn(dev_rsp_ppn),
        .dev_rsp_attr(dev_rsp_attr),
        .fq_valid(fq_valid), .fq_ready(fq_ready), .fq_cause(fq_cause),
        .fq_iova(fq_iova), .fq_did(fq_did), .pmu_untrans(pmu_untrans)
    );

    dbg_xlate_ctrl #(.CAP_DEBUG(1'b0)) uut_nocap (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_ready(nc_bus_ready), .bus_write(bus_write),
        .bus_off(bus_off), .bus_wdata(bus_wdata),
        .bus_rvalid(nc_bus_rvalid), .bus_rdata(nc_bus_rdata),
        .dev_req_valid(dev_req_valid), .dev_req_ready(nc_dev_req_ready),
        .dev_req_iova(dev_req_iova), .dev_req_did(dev_req_did),
        .dev_req_write(dev_req_write), .dev_req_untrans(dev_req_untrans),
        .eng_req_valid(nc_eng_req_valid), .eng_req_ready(eng_req_ready),
        .eng_req_iova(nc_eng_req_iova), .eng_req_did(nc_eng_req_did),
        .eng_req_write(nc_eng_req_write), .eng_req_untrans(nc_eng_req_untrans),
        .eng_req_dbg(nc_eng_req_dbg),
        .eng_rsp_valid(eng_rsp_valid), .eng_rsp_dbg(eng_rsp_dbg),
        .eng_rsp_fault(eng_rsp_fault), .eng_rsp_mrif(eng_rsp_mrif),
        .eng_rsp_cause(eng_rsp_cause), .eng_rsp_ppn(eng_rsp_ppn),
        .eng_rsp_attr(eng_rsp_attr),
        .dev_rsp_valid(nc_dev_rsp_valid), .dev_rsp_fault(nc_dev_rsp_fault),
        .dev_rsp_cause(nc_dev_rsp_cause), .dev_rsp_ppn(nc_dev_rsp_ppn),
        .dev_rsp_attr(nc_dev_rsp_attr),
        .fq_valid(nc_fq_valid), .fq_ready(fq_ready), .fq_cause(nc_fq_cause),
        .fq_iova(nc_fq_iova), .fq_did(nc_fq_did), .pmu_untrans(nc_pmu_untrans)
    );

    typedef struct packed {
        logic [63:0] iova;
        logic [15:0] did;
        logic        wr;
        logic        flt;
        logic        mrif;
        logic [11:0] cause;
        logic [53:0] ppn;
        logic [8:0]  attr;
    } vec_t;

    localparam int NVEC = 4;
    localparam vec_t VECS [NVEC] = '{
        '{64'h0000_0040_1234_5000, 16'h0011, 1'b0, 1'b0, 1'b0, 12'd0,  54'h00_0000_000A_BCDE, 9'h0C3},
        '{64'h0000_7FFF_FFFF_F000, 16'hBEEF, 1'b1, 1'b0, 1'b0, 12'd0,  54'h3F_FFFF_FFFF_FFFF, 9'h1FF},
        '{64'h0000_0000_0000_1000, 16'h0002, 1'b0, 1'b1, 1'b0, 12'd13, 54'h00_0000_0000_0123, 9'h005},
        '{64'h0000_0002_0000_0000, 16'h0300, 1'b1, 1'b0, 1'b1, 12'd7,  54'h00_0000_0000_0077, 9'h001}
    };

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    logic [63:0] rd;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] off, input logic [63:0] data);
        bus_valid = 1; bus_write = 1; bus_off = off; bus_wdata = data;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic bus_rd(input logic [2:0] off, output logic [63:0] data);
        bus_valid = 1; bus_write = 0; bus_off = off;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 0;
        checks++;
        if (bus_rvalid !== 1'b1) begin
            errors++;
            $display("FAIL R12 rvalid actual=%b expected=1", bus_rvalid);
        end
        data = bus_rdata;
    endtask

    function automatic logic [63:0] ctl_word(input logic go, input logic wr, input logic [15:0] did);
        return {32'd0, did, 13'd0, wr, 1'b0, go};
    endfunction

    task automatic send_rsp(input logic dbg, input logic flt, input logic mrif,
                            input logic [11:0] cause, input logic [53:0] ppn, input logic [8:0] attr);
        eng_rsp_valid = 1; eng_rsp_dbg = dbg; eng_rsp_fault = flt; eng_rsp_mrif = mrif;
        eng_rsp_cause = cause; eng_rsp_ppn = ppn; eng_rsp_attr = attr;
        @(posedge clk);
        @(negedge clk);
        eng_rsp_valid = 0; eng_rsp_dbg = 0; eng_rsp_fault = 0; eng_rsp_mrif = 0;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] exp_rslt;
        logic        bad;
        logic [11:0] exp_cause;
        int          dev_lost;
        bit          got_dbg;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 engine idle", {63'd0, eng_req_valid}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        check("R12 bus_ready", {63'd0, bus_ready}, 64'd1);
        bus_rd(3'd0, rd); check("R1 addr reset", rd, 64'd0);
        bus_rd(3'd1, rd); check("R1 ctl reset", rd, 64'd0);
        bus_rd(3'd2, rd); check("R1 rslt reset", rd, 64'd0);

        // Vector table: R3 launch contents, R6 clean result, R7 fault, R8 memory-resident mode
        for (int i = 0; i < NVEC; i++) begin
            bad       = VECS[i].flt | VECS[i].mrif;
            exp_cause = VECS[i].mrif ? 12'd260 : VECS[i].cause;
            exp_rslt  = bad ? 64'd1 : {VECS[i].ppn, VECS[i].attr, 1'b0};
            bus_wr(3'd0, VECS[i].iova);
            bus_wr(3'd1, ctl_word(1'b1, VECS[i].wr, VECS[i].did));
            check($sformatf("R3 v%0d req valid+dbg", i), {62'd0, eng_req_valid, eng_req_dbg}, 64'd3);
            check($sformatf("R3 v%0d iova", i), eng_req_iova, VECS[i].iova);
            check($sformatf("R3 v%0d did/wr/untrans", i),
                  {46'd0, eng_req_did, eng_req_write, eng_req_untrans},
                  {46'd0, VECS[i].did, VECS[i].wr, 1'b1});
            check($sformatf("R11 v%0d pmu", i), {63'd0, pmu_untrans}, 64'd1);
            @(posedge clk);
            @(negedge clk);
            send_rsp(1'b1, VECS[i].flt, VECS[i].mrif, VECS[i].cause, VECS[i].ppn, VECS[i].attr);
            if (bad) begin
                check($sformatf("R7 v%0d fq_valid", i), {63'd0, fq_valid}, 64'd1);
                check($sformatf("R8 v%0d fq_cause", i), {52'd0, fq_cause}, {52'd0, exp_cause});
                check($sformatf("R7 v%0d fq_iova", i), fq_iova, VECS[i].iova);
                check($sformatf("R7 v%0d fq_did", i), {48'd0, fq_did}, {48'd0, VECS[i].did});
                @(posedge clk);
                @(negedge clk);
                check($sformatf("R7 v%0d fq held", i), {63'd0, fq_valid}, 64'd1);
                fq_ready = 1;
                @(posedge clk);
                @(negedge clk);
                fq_ready = 0;
                check($sformatf("R7 v%0d fq dropped", i), {63'd0, fq_valid}, 64'd0);
            end
            bus_rd(3'd1, rd);
            check($sformatf("R4 v%0d busy cleared", i), {63'd0, rd[0]}, 64'd0);
            bus_rd(3'd2, rd);
            check($sformatf("R6 v%0d result", i), rd, exp_rslt);
        end

        // Directed: R4 W1S, R5 dropped writes and error flag, R6 result write ignored
        eng_req_ready = 0;
        bus_wr(3'd0, 64'h0000_0000_00AA_A000);
        bus_wr(3'd1, ctl_word(1'b1, 1'b0, 16'h0055));
        bus_rd(3'd1, rd);
        check("R4 busy reads 1", {63'd0, rd[0]}, 64'd1);
        bus_wr(3'd1, 64'd0);
        bus_rd(3'd1, rd);
        check("R4 write 0 keeps busy", {63'd0, rd[0]}, 64'd1);
        check("R5 error flag set", {63'd0, rd[1]}, 64'd1);
        bus_wr(3'd0, 64'h0000_0000_00BB_B000);
        bus_wr(3'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        eng_req_ready = 1;
        @(negedge clk);
        @(negedge clk);
        send_rsp(1'b1, 1'b0, 1'b0, 12'd0, 54'h1234, 9'h0AA);
        bus_rd(3'd0, rd);
        check("R5 addr write dropped", rd, 64'h0000_0000_00AA_A000);
        bus_rd(3'd2, rd);
        check("R6 result after offset-2 write", rd, {54'h1234, 9'h0AA, 1'b0});
        bus_rd(3'd1, rd);
        check("R5 error flag sticky", {63'd0, rd[1]}, 64'd1);
        bus_wr(3'd1, 64'h2);
        bus_rd(3'd1, rd);
        check("R5 error flag cleared", {63'd0, rd[1]}, 64'd0);

        // Directed: R11 translated device request does not count
        dev_req_valid = 1; dev_req_untrans = 0; dev_req_iova = 64'h5000; dev_req_did = 16'h7;
        #1;
        check("R11 translated device no pmu", {62'd0, dev_req_ready, pmu_untrans}, 64'd2);
        dev_req_untrans = 1;
        #1;
        check("R11 untranslated device pmu", {63'd0, pmu_untrans}, 64'd1);

        // Directed: R9 bounded wait against continuous device traffic
        bus_wr(3'd1, ctl_word(1'b1, 1'b0, 16'h0042));
        dev_lost = 0;
        got_dbg  = 0;
        for (int c = 0; c < 8 && !got_dbg; c++) begin
            if (eng_req_valid && eng_req_ready && eng_req_dbg) begin
                got_dbg = 1;
                check("R9 device held off", {63'd0, dev_req_ready}, 64'd0);
            end else if (dev_req_ready) begin
                dev_lost++;
            end
            @(posedge clk);
            @(negedge clk);
        end
        check("R9 debug granted", {63'd0, got_dbg}, 64'd1);
        checks++;
        if (dev_lost > 1) begin
            errors++;
            $display("FAIL R9 device grants before debug actual=%0d expected<=1", dev_lost);
        end
        dev_req_valid = 0;

        // Directed: R10 device response forwarded, debug stays busy
        eng_rsp_valid = 1; eng_rsp_dbg = 0; eng_rsp_ppn = 54'h0F0F; eng_rsp_attr = 9'h033;
        #1;
        check("R10 dev rsp valid", {63'd0, dev_rsp_valid}, 64'd1);
        check("R10 dev rsp ppn", {10'd0, dev_rsp_ppn}, {10'd0, 54'h0F0F});
        @(posedge clk);
        @(negedge clk);
        eng_rsp_valid = 0;
        bus_rd(3'd1, rd);
        check("R10 debug still busy", {63'd0, rd[0]}, 64'd1);
        send_rsp(1'b1, 1'b0, 1'b0, 12'd0, 54'h2222, 9'h011);
        bus_rd(3'd2, rd);
        check("R6 result after arbitration", rd, {54'h2222, 9'h011, 1'b0});

        // Directed: R2 disabled variant
        bus_wr(3'd0, 64'h0000_0000_0009_9000);
        check("R2 nocap addr read after write", nc_bus_rdata, 64'd0);
        bus_wr(3'd1, ctl_word(1'b1, 1'b1, 16'h0001));
        check("R2 nocap no debug request", {63'd0, nc_eng_req_dbg}, 64'd0);
        bus_rd(3'd0, rd);
        check("R2 nocap addr reads 0", nc_bus_rdata, 64'd0);
        bus_rd(3'd1, rd);
        check("R2 nocap ctl reads 0", nc_bus_rdata, 64'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule